// File: doc/BRIEF.md
# Successive Cancellation Polar Decoder

This block turns one received polar codeword, given as N signed log-likelihood ratios (LLRs), into the N estimated source bits by successive cancellation. A positive LLR favours a transmitted 0. The set of positions that carry no information is fixed at build time by the parameter `FROZEN`, an N-bit mask. Bit i set means source position i is frozen. The default is N = 8 with `FROZEN = 8'b0001_0111`, so positions 0, 1, 2 and 4 are frozen and 3, 5, 6 and 7 carry data.

A one-cycle pulse on `start` captures the whole LLR vector. The decoder then walks the code tree depth-first, one node operation per clock cycle:
- a min-sum update towards a left child;
- a sign-controlled add or subtract towards a right child, using the left sibling's partial sums;
- a hard decision at a leaf;
- an XOR combine of partial sums on the way back up.

When the walk ends, `done` pulses for one cycle and `decodedBits` holds every decision in natural index order. The output stays there until the next frame completes. No state carries over from one frame to the next.

Top module: `sc_polar_decoder`

## Requirements
- R1: Left-child update: the result's sign is the XOR of the two input sign bits, and its magnitude is the smaller input magnitude. The most negative code (-2^(W-1)) counts as magnitude 2^(W-1). A positive result of that magnitude saturates to 2^(W-1)-1.
- R2: Right-child update, where a is the upper-half LLR, b the lower-half LLR and s the left sibling's partial-sum bit: the result is b+a when s is 0 and b-a when s is 1, saturated to [-2^(W-1), 2^(W-1)-1].
- R3: Partial sums combine as (sa XOR sb, sb), with sa in the lower half of the parent vector, so x = u·F^{⊗n} in natural order. For a noiseless codeword, the information word is recovered exactly. Codeword position i is carried by `llrIn[i*W +: W]`.
- R4: Leaves are decided in index order 0..N-1. Each left/right update uses the partial sums of the leaves already decided, so the output equals the successive-cancellation result for any LLR vector.
- R5: A leaf whose `FROZEN` bit is set is decided 0 whatever its LLR. Every bit at a frozen position of `decodedBits` is 0 when `done` is high.
- R6: At an information leaf the decision is 1 for a negative LLR and 0 otherwise; an LLR of exactly 0 gives 0.
- R7: `done` rises exactly 4N-3 clock edges after the edge that accepts `start` (29 for N = 8) and stays high for exactly one cycle.
- R8: A `start` pulse while a frame is being decoded is ignored. The running frame's result and its completion time are unchanged.
- R9: `decodedBits` changes only at the edge where `done` rises and otherwise holds its value. Each frame's result depends only on that frame's LLRs.
- R10: During and right after reset, `done` is 0 and `decodedBits` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new frame when idle |
| llrIn | input | N*W | Channel LLRs, position i at bits [i*W +: W], two's complement |
| done | output | 1 | One-cycle pulse when a frame has been decoded |
| decodedBits | output | N | Decided source bits, bit i is position i |

## Verification
Noiseless codewords of every information word separate a correct partial-sum combine and bit ordering from a wrong one, because each word must come back exactly. Pseudo-random LLR vectors over the full signed range are checked against a successive-cancellation model built from the per-leaf encode of earlier decisions. These vectors expose errors in the min-sum magnitude, in the add/subtract choice and in saturation. All-zero, all-most-negative and all-negative frames probe the zero-LLR decision, the largest-magnitude code and forced frozen zeros. A start pulse injected mid-frame, followed by an idle hold, shows whether busy starts are ignored and whether the result is retained.

// File: rtl/sc_polar_pkg.sv
package sc_polar_pkg;

  // node operation issued by the traversal control each cycle
  typedef enum logic [1:0] {
    OP_F    = 2'd0,  // min-sum towards left child
    OP_G    = 2'd1,  // add/subtract towards right child
    OP_LEAF = 2'd2,  // hard decision at a leaf
    OP_H    = 2'd3   // partial-sum combine upwards
  } nodeOp_e;

  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_LEAF = 2'd1,
    PH_UP   = 2'd2
  } walkPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        load;       // capture llrIn
    logic        act;        // an operation is issued
    nodeOp_e     op;
    logic [7:0]  level;      // F/G: parent level, H: child level
    logic [15:0] leaf;       // current leaf index
    logic        storeLeft;  // result is a left child, keep it
    logic        finish;     // last operation of the frame
  } ctrlStrobe_t;

endpackage

// File: rtl/sc_polar_pe.sv
// One processing element: left (min-sum) or right (add/subtract) update.
module sc_polar_pe #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                s,
  input  logic                selG,
  output logic signed [W-1:0] y
);
  localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

  logic signed [W:0] aExt, bExt, magA, magB, mag, fVal, gVal, pick;
  logic              fNeg;

  always_comb begin
    aExt = {a[W-1], a};
    bExt = {b[W-1], b};
    // R1: most negative code has the largest magnitude
    magA = a[W-1] ? -aExt : aExt;
    magB = b[W-1] ? -bExt : bExt;
    mag  = (magA < magB) ? magA : magB;
    fNeg = a[W-1] ^ b[W-1];
    fVal = fNeg ? -mag : mag;
    // R2: sign of a flipped by the partial sum
    gVal = s ? (bExt - aExt) : (bExt + aExt);
    pick = selG ? gVal : fVal;
    if (pick > MAXV)      y = MAXV[W-1:0];
    else if (pick < MINV) y = MINV[W-1:0];
    else                  y = pick[W-1:0];
  end
endmodule

// File: rtl/sc_polar_ctrl.sv
// Depth-first tree walk: issues one node operation per cycle.
module sc_polar_ctrl
  import sc_polar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strb,
  output logic        done
);
  localparam int NLVL = $clog2(N);
  localparam int LVLW = $clog2(NLVL + 1) + 1;

  logic             running;
  walkPhase_e       phase;
  logic [LVLW-1:0]  lvl;
  logic [NLVL-1:0]  leafIdx;
  logic             firstG;
  logic             parentBit;

  always_comb begin
    parentBit = 1'b1;
    if (int'(lvl) + 1 < NLVL) parentBit = leafIdx[lvl + 1'b1];
  end

  always_comb begin
    strb      = '0;
    strb.load = start && !running;  // R8: start ignored while running
    if (running) begin
      strb.act  = 1'b1;
      strb.leaf = 16'(leafIdx);
      unique case (phase)
        PH_DOWN: begin
          strb.op    = firstG ? OP_G : OP_F;
          strb.level = 8'(lvl);
        end
        PH_LEAF: begin
          strb.op        = OP_LEAF;
          strb.level     = 8'd0;
          strb.storeLeft = !leafIdx[0];
        end
        default: begin
          strb.op        = OP_H;
          strb.level     = 8'(lvl);
          strb.finish    = (int'(lvl) == NLVL - 1);
          strb.storeLeft = (int'(lvl) != NLVL - 1) && !parentBit;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= PH_DOWN;
      lvl     <= '0;
      leafIdx <= '0;
      firstG  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= strb.finish;  // R7
      if (strb.load) begin
        running <= 1'b1;
        phase   <= PH_DOWN;
        lvl     <= LVLW'(NLVL);
        leafIdx <= '0;
        firstG  <= 1'b0;
      end else if (running) begin
        unique case (phase)
          PH_DOWN: begin
            firstG <= 1'b0;
            lvl    <= lvl - 1'b1;
            if (lvl == LVLW'(1)) phase <= PH_LEAF;
          end
          PH_LEAF: begin
            if (!leafIdx[0]) begin
              leafIdx <= leafIdx + 1'b1;
              lvl     <= LVLW'(1);
              firstG  <= 1'b1;
              phase   <= PH_DOWN;
            end else begin
              lvl   <= '0;
              phase <= PH_UP;
            end
          end
          default: begin
            if (strb.finish) begin
              running <= 1'b0;
            end else if (strb.storeLeft) begin
              leafIdx <= leafIdx + 1'b1;
              lvl     <= lvl + LVLW'(2);
              firstG  <= 1'b1;
              phase   <= PH_DOWN;
            end else begin
              lvl <= lvl + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sc_polar_datapath.sv
// LLR and partial-sum storage with the per-level processing elements.
module sc_polar_datapath
  import sc_polar_pkg::*;
#(
  parameter int             N      = 8,
  parameter int             W      = 8,
  parameter logic [N-1:0]   FROZEN = 8'b0001_0111
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strb,
  input  logic [N*W-1:0] llrIn,
  output logic [N-1:0]  decodedBits
);
  localparam int NLVL = $clog2(N);
  localparam int LW   = $clog2(NLVL + 1);

  logic signed [W-1:0] alpha    [NLVL+1][N];
  logic signed [W-1:0] childLlr [NLVL+1][N];
  logic [N-1:0]        betaLeft [NLVL];
  logic [N-1:0]        curBeta;
  logic [N-1:0]        uWork;
  logic [N-1:0]        resBeta;
  logic [LW-1:0]       nodeLvl, dstLvl, resLvl, saLvl;
  logic [NLVL-1:0]     leafSel;
  logic                decision;
  logic                selG;

  assign selG = (strb.op == OP_G);

  // one PE per upper/lower pair at every level
  for (genvar l = 0; l <= NLVL; l++) begin : gLvl
    for (genvar j = 0; j < N; j++) begin : gPe
      if (l >= 1 && j < (1 << (l - 1))) begin : gAct
        sc_polar_pe #(.W(W)) uPe (
          .a    (alpha[l][j]),
          .b    (alpha[l][j + (1 << (l - 1))]),
          .s    (betaLeft[l-1][j]),
          .selG (selG),
          .y    (childLlr[l][j])
        );
      end else begin : gIdle
        assign childLlr[l][j] = '0;
      end
    end
  end

  always_comb begin
    nodeLvl  = LW'(strb.level);
    dstLvl   = nodeLvl - 1'b1;
    leafSel  = strb.leaf[NLVL-1:0];
    saLvl    = (int'(strb.level) < NLVL) ? LW'(strb.level) : '0;
    // R5 frozen leaf forced to 0; R6 negative LLR gives 1, zero gives 0
    decision = FROZEN[leafSel] ? 1'b0 : alpha[0][0][W-1];
    resBeta  = '0;
    resLvl   = '0;
    if (strb.op == OP_LEAF) begin
      resBeta[0] = decision;
    end else begin
      // R3: combine (sa ^ sb, sb)
      for (int j = 0; j < N; j++) begin
        if (j < (1 << strb.level))
          resBeta[j] = betaLeft[saLvl][j] ^ curBeta[j];
        else if (j < (2 << strb.level))
          resBeta[j] = curBeta[j - (1 << strb.level)];
      end
      resLvl = saLvl + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l <= NLVL; l++)
        for (int j = 0; j < N; j++) alpha[l][j] <= '0;
      for (int l = 0; l < NLVL; l++) betaLeft[l] <= '0;
      curBeta     <= '0;
      uWork       <= '0;
      decodedBits <= '0;
    end else begin
      if (strb.load)
        for (int j = 0; j < N; j++) alpha[NLVL][j] <= llrIn[j*W +: W];
      if (strb.act) begin
        unique case (strb.op)
          OP_F, OP_G: begin
            for (int j = 0; j < N; j++)
              if (j < (1 << (int'(nodeLvl) - 1)))
                alpha[dstLvl][j] <= childLlr[nodeLvl][j];
          end
          OP_LEAF: begin
            uWork[leafSel] <= decision;
            curBeta        <= resBeta;
            if (strb.storeLeft) betaLeft[0] <= resBeta;
          end
          default: begin
            curBeta <= resBeta;
            if (strb.storeLeft) betaLeft[resLvl] <= resBeta;
          end
        endcase
      end
      // R9: result published only on completion
      if (strb.finish) decodedBits <= uWork;
    end
  end
endmodule

// File: rtl/sc_polar_decoder.sv
module sc_polar_decoder
  import sc_polar_pkg::*;
#(
  parameter int           N      = 8,
  parameter int           W      = 8,
  parameter logic [N-1:0] FROZEN = 8'b0001_0111
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N*W-1:0] llrIn,
  output logic           done,
  output logic [N-1:0]   decodedBits
);
  ctrlStrobe_t strb;

  sc_polar_ctrl #(.N(N)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  sc_polar_datapath #(.N(N), .W(W), .FROZEN(FROZEN)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .llrIn       (llrIn),
    .decodedBits (decodedBits)
  );
endmodule

// File: rtl/sc_polar_decoder_chk.sv
module sc_polar_decoder_chk #(
  parameter int           N      = 8,
  parameter int           W      = 8,
  parameter logic [N-1:0] FROZEN = 8'b0001_0111
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         done,
  input logic [N-1:0] decodedBits
);
  localparam int LAT = 4 * N - 3;

  logic inFlight;
  int   cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      cnt      <= 0;
    end else if (start && (!inFlight || done)) begin
      inFlight <= 1'b1;
      cnt      <= 0;
    end else begin
      if (done) inFlight <= 1'b0;
      if (inFlight) cnt <= cnt + 1;
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (inFlight && cnt == LAT));

  // R8
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && cnt < LAT) |-> !done);

  // R5
  frozen_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((decodedBits & FROZEN) == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> $stable(decodedBits));
endmodule

bind sc_polar_decoder sc_polar_decoder_chk #(.N(N), .W(W), .FROZEN(FROZEN)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .done        (done),
  .decodedBits (decodedBits)
);

// File: tb/sim_sc_polar_decoder.sv
module sim_sc_polar_decoder;
  localparam int           N      = 8;
  localparam int           W      = 8;
  localparam int           NLVL   = 3;
  localparam int           LAT    = 4 * N - 3;
  localparam logic [N-1:0] FROZEN = 8'b0001_0111;
  localparam int           MAXV   = 127;
  localparam int           MINV   = -128;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] llrIn = '0;
  logic           done;
  logic [N-1:0]   decodedBits;

  sc_polar_decoder #(.N(N), .W(W), .FROZEN(FROZEN)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .llrIn(llrIn),
    .done(done), .decodedBits(decodedBits)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0;
  int nBad = 0;
  logic [N-1:0] expQ[$];
  int           edgeQ[$];
  string        tagQ[$];
  logic [N-1:0] lastExp = '0;
  bit           pendLow = 1'b0;
  int           seed = 32'h1234_5678;

  task automatic report(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic int fm(input int a, input int b);
    int ma, mb, m;
    ma = (a < 0) ? -a : a;
    mb = (b < 0) ? -b : b;
    m  = (ma < mb) ? ma : mb;
    return clampv(((a < 0) != (b < 0)) ? -m : m);
  endfunction

  function automatic int gm(input int a, input int b, input int s);
    return clampv((s != 0) ? (b - a) : (b + a));
  endfunction

  // reference: per-leaf walk, sibling partial sums re-encoded from decided bits
  function automatic logic [N-1:0] refDecode(input logic [N*W-1:0] vec);
    int a[N];
    int b[N];
    int x[N];
    int size, base, half;
    logic [N-1:0] u;
    u = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) a[j] = int'($signed(vec[j*W +: W]));
      size = N;
      base = 0;
      for (int l = NLVL; l >= 1; l--) begin
        half = size / 2;
        if (((i >> (l - 1)) & 1) == 0) begin
          for (int j = 0; j < half; j++) b[j] = fm(a[j], a[j+half]);
        end else begin
          for (int j = 0; j < half; j++) x[j] = int'(u[base+j]);
          for (int h = 1; h < half; h = h * 2)
            for (int st = 0; st < half; st = st + 2 * h)
              for (int j = st; j < st + h; j++) x[j] = x[j] ^ x[j+h];
          for (int j = 0; j < half; j++) b[j] = gm(a[j], a[j+half], x[j]);
          base = base + half;
        end
        for (int j = 0; j < half; j++) a[j] = b[j];
        size = half;
      end
      u[i] = FROZEN[i] ? 1'b0 : (a[0] < 0);
    end
    return u;
  endfunction

  function automatic logic [N*W-1:0] encode(input logic [N-1:0] u, input int mag);
    logic [N-1:0]   x;
    logic [N*W-1:0] v;
    x = u;
    for (int h = 1; h < N; h = h * 2)
      for (int st = 0; st < N; st = st + 2 * h)
        for (int j = st; j < st + h; j++) x[j] = x[j] ^ x[j+h];
    for (int j = 0; j < N; j++) v[j*W +: W] = x[j] ? W'(-mag) : W'(mag);
    return v;
  endfunction

  function automatic logic [N-1:0] infoWord(input int k);
    logic [N-1:0] u;
    int p;
    u = '0;
    p = 0;
    for (int i = 0; i < N; i++)
      if (!FROZEN[i]) begin
        u[i] = k[p];
        p++;
      end
    return u;
  endfunction

  function automatic logic [N*W-1:0] randVec();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) begin
      seed = seed * 1103515245 + 12345;
      v[j*W +: W] = W'(seed >>> 16);
    end
    return v;
  endfunction

  // driver: pushes expectation and fires start
  task automatic sendFrame(input logic [N*W-1:0] vec, input logic [N-1:0] exp,
                           input string tag);
    @(negedge clk);
    llrIn = vec;
    start = 1'b1;
    expQ.push_back(exp);
    edgeQ.push_back(cyc + 1);
    tagQ.push_back(tag);
    lastExp = exp;
    @(negedge clk);
    start = 1'b0;
    wait (expQ.size() == 0);
  endtask

  // monitor: pops and compares on each completion
  always @(negedge clk) begin
    if (pendLow) begin
      report(!done, "R7 done single cycle", 32'(done), 32'd0);
      pendLow = 1'b0;
    end
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        report(1'b0, "R8 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [N-1:0] e;
        int           ed;
        string        t;
        e  = expQ.pop_front();
        ed = edgeQ.pop_front();
        t  = tagQ.pop_front();
        report(decodedBits == e, t, 32'(decodedBits), 32'(e));
        report(cyc - ed == LAT, "R7 latency", 32'(cyc - ed), 32'(LAT));
        report((decodedBits & FROZEN) == '0, "R5 frozen positions zero",
               32'(decodedBits & FROZEN), 32'd0);
        pendLow = 1'b1;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    report(done == 1'b0, "R10 done in reset", 32'(done), 32'd0);
    report(decodedBits == '0, "R10 bits in reset", 32'(decodedBits), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    report(done == 1'b0, "R10 done after reset", 32'(done), 32'd0);
    report(decodedBits == '0, "R10 bits after reset", 32'(decodedBits), 32'd0);

    // R3: every information word over a clean channel
    for (int k = 0; k < 16; k++)
      sendFrame(encode(infoWord(k), 20), infoWord(k), "R3 noiseless info word");

    // R6: all-zero LLRs decide 0 everywhere
    sendFrame('0, '0, "R6 zero llr gives zero");
    // R1: most negative code everywhere
    sendFrame({N{8'h80}}, refDecode({N{8'h80}}), "R1 most negative llr");
    // R5: strongly negative everywhere, frozen leaves still 0
    sendFrame({N{8'h9C}}, refDecode({N{8'h9C}}), "R5 negative frozen leaves");
    // R2/R4: mixed full-range vectors against the reference walk
    for (int r = 0; r < 40; r++) begin
      logic [N*W-1:0] v;
      v = randVec();
      sendFrame(v, refDecode(v), "R2 R4 mixed llr");
    end
    // R4: noisy codeword with weak wrong-sign samples
    begin
      logic [N*W-1:0] v;
      v = encode(infoWord(11), 30);
      v[5*W +: W] = 8'd4;
      v[6*W +: W] = 8'hFD;
      sendFrame(v, refDecode(v), "R4 noisy codeword");
    end

    // R8: second start while busy is ignored
    @(negedge clk);
    llrIn = encode(infoWord(9), 25);
    start = 1'b1;
    expQ.push_back(infoWord(9));
    edgeQ.push_back(cyc + 1);
    tagQ.push_back("R8 start while busy");
    lastExp = infoWord(9);
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    llrIn = encode(infoWord(6), 25);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    llrIn = randVec();
    wait (expQ.size() == 0);

    // R9: result held while idle with changing inputs
    repeat (4) @(negedge clk);
    llrIn = randVec();
    repeat (3) @(negedge clk);
    report(decodedBits == lastExp, "R9 result held", 32'(decodedBits), 32'(lastExp));
    report(done == 1'b0, "R9 no spurious done", 32'(done), 32'd0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule